// File: doc/BRIEF.md
# Indirect Oscillator Configuration Channel

This block gives software indirect access to a small bank of 32-bit oscillator setting registers through four words of a plain 32-bit register port. Software first loads the outgoing data word. It then writes a control word that names a target register index, a function code, a direction (read or write) and a start flag. The block runs the transfer against the internal bank and reports the result in a two-bit status word. Bit 0 of the status word is done and bit 1 is error.

The only target the block accepts is function code 1 with an index below the number of bank registers. Any other target ends with both error and done set, and leaves every register as it was. A read places the selected register's value in the return word. Each bank register starts from its own reset constant, so a platform can set the power-up clock settings without software.

Top module: `cfgchan_xact`

## Requirements
- R1: Reads at offset 0xA0 return the return word, 0xA4 the outgoing data word, 0xA8 the stored control word and 0xAC the status word in bits [1:0] with zeros above. Every other offset reads as 0.
- R2: A control write keeps only device index [11:0], function code [25:20] and direction bit [30], where 1 means write. Bits [19:12], [29:26] and the start bit [31] are discarded and read back as 0.
- R3: Any write to the control word clears the status word to 0 on the next cycle, whatever the status was before.
- R4: A control write with bit 31 set starts a transfer, and status bit 0 (done) reads 1 from the second clock edge after the write. A control write with bit 31 clear leaves the status at 0.
- R5: A transfer is valid only when the function code is 1 and the device index is below NUM_OSC. Any other transfer sets the status to 3 (error and done) and changes neither the bank nor the return word.
- R6: A valid transfer with direction 1 copies the outgoing data word into the bank register selected by the device index, and the status reads 1.
- R7: A valid transfer with direction 0 copies the selected bank register into the return word, and the status reads 1.
- R8: After reset the control word reads 0x00100000, and the status, outgoing data and return words read 0. Bank register i holds bits [32*i+31:32*i] of OSC_INIT.
- R9: The outgoing data word is written at 0xA4. Software writes to the return word at 0xA0 have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| busWrEn | input | 1 | Write strobe for the register port |
| busAddr | input | 12 | Byte offset of the access |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for busAddr, combinational |

## Verification
The bench builds the block with NUM_OSC set to 3 and gives each bank register a different reset constant. Device index 2 is then the last valid target and index 3 is the first invalid one, so the edge of the index check can be reached. An index of 0xFFF and function codes 0, 2 and 0x3F test the other invalid targets. Because the reset constants all differ, a read from the wrong register, or a bank register that changes on a rejected transfer, shows up in the return word.

// File: rtl/cfgchan_pkg.sv
package cfgchan_pkg;

  localparam int REG_W  = 32;
  localparam int ADDR_W = 12;

  localparam logic [ADDR_W-1:0] OFS_RTN  = 12'h0A0;
  localparam logic [ADDR_W-1:0] OFS_OUT  = 12'h0A4;
  localparam logic [ADDR_W-1:0] OFS_CTRL = 12'h0A8;
  localparam logic [ADDR_W-1:0] OFS_STAT = 12'h0AC;

  localparam int DEV_LSB = 0;
  localparam int DEV_W   = 12;
  localparam int FN_LSB  = 20;
  localparam int FN_W    = 6;
  localparam int DIR_BIT = 30;
  localparam int GO_BIT  = 31;

  localparam logic [REG_W-1:0] CTRL_KEEP  = 32'h43F0_0FFF;
  localparam logic [REG_W-1:0] CTRL_RESET = 32'h0010_0000;
  localparam logic [FN_W-1:0]  FN_OSC     = 6'd1;

  typedef struct packed {
    logic ldCtrl;
    logic ldOut;
    logic ldRtn;
    logic ldOsc;
    logic setStat;
    logic statErr;
  } strobe_t;

endpackage

// File: rtl/cfgchan_ctrl.sv
module cfgchan_ctrl
  import cfgchan_pkg::*;
#(
  parameter int NUM_OSC = 4,
  parameter int SEL_W   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busWrEn,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busGoBit,
  input  logic [DEV_W-1:0]  ctrlDev,
  input  logic [FN_W-1:0]   ctrlFn,
  input  logic              ctrlDir,
  output strobe_t           stb,
  output logic [SEL_W-1:0]  oscSel
);

  localparam logic [DEV_W-1:0] OSC_LIMIT = DEV_W'(NUM_OSC);

  logic goQ;
  logic ctrlHit;
  logic targetOk;

  assign ctrlHit  = busWrEn && (busAddr == OFS_CTRL);
  assign targetOk = (ctrlFn == FN_OSC) && (ctrlDev < OSC_LIMIT);
  assign oscSel   = ctrlDev[SEL_W-1:0];

  // transfer runs one cycle after the accepting edge, on the stored fields
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) goQ <= 1'b0;
    else       goQ <= ctrlHit && busGoBit;
  end

  always_comb begin
    stb         = '0;
    stb.ldCtrl  = ctrlHit;
    stb.ldOut   = busWrEn && (busAddr == OFS_OUT);
    stb.ldOsc   = goQ && targetOk && ctrlDir;
    stb.ldRtn   = goQ && targetOk && !ctrlDir;
    stb.setStat = goQ && !ctrlHit;
    stb.statErr = !targetOk;
  end

endmodule

// File: rtl/cfgchan_datapath.sv
module cfgchan_datapath
  import cfgchan_pkg::*;
#(
  parameter int                       NUM_OSC  = 4,
  parameter int                       SEL_W    = 2,
  parameter logic [NUM_OSC*REG_W-1:0] OSC_INIT = '0
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic [SEL_W-1:0]  oscSel,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [REG_W-1:0]  busWrData,
  output logic [REG_W-1:0]  busRdData,
  output logic [REG_W-1:0]  ctrlQ,
  output logic [1:0]        statQ,
  output logic [REG_W-1:0]  rtnQ,
  output logic [DEV_W-1:0]  ctrlDev,
  output logic [FN_W-1:0]   ctrlFn,
  output logic              ctrlDir
);

  logic [REG_W-1:0] outQ;
  logic [REG_W-1:0] oscQ [NUM_OSC];
  logic [REG_W-1:0] oscRd;

  assign ctrlDev = ctrlQ[DEV_LSB +: DEV_W];
  assign ctrlFn  = ctrlQ[FN_LSB +: FN_W];
  assign ctrlDir = ctrlQ[DIR_BIT];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ctrlQ <= CTRL_RESET;
      outQ  <= '0;
      rtnQ  <= '0;
      statQ <= 2'b00;
    end else begin
      if (stb.ldCtrl) ctrlQ <= busWrData & CTRL_KEEP;
      if (stb.ldOut)  outQ  <= busWrData;
      if (stb.ldRtn)  rtnQ  <= oscRd;
      if (stb.ldCtrl)       statQ <= 2'b00;
      else if (stb.setStat) statQ <= {stb.statErr, 1'b1};
    end
  end

  for (genvar g = 0; g < NUM_OSC; g++) begin : g_osc
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)
        oscQ[g] <= OSC_INIT[g*REG_W +: REG_W];
      else if (stb.ldOsc && (oscSel == SEL_W'(g)))
        oscQ[g] <= outQ;
    end
  end

  always_comb begin
    oscRd = '0;
    for (int i = 0; i < NUM_OSC; i++)
      if (oscSel == SEL_W'(i)) oscRd = oscQ[i];
  end

  always_comb begin
    unique case (busAddr)
      OFS_RTN:  busRdData = rtnQ;
      OFS_OUT:  busRdData = outQ;
      OFS_CTRL: busRdData = ctrlQ;
      OFS_STAT: busRdData = {{(REG_W-2){1'b0}}, statQ};
      default:  busRdData = '0;
    endcase
  end

endmodule

// File: rtl/cfgchan_xact.sv
module cfgchan_xact
  import cfgchan_pkg::*;
#(
  parameter int                       NUM_OSC  = 4,
  parameter logic [NUM_OSC*REG_W-1:0] OSC_INIT = '0
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        busWrEn,
  input  logic [11:0] busAddr,
  input  logic [31:0] busWrData,
  output logic [31:0] busRdData
);

  localparam int SEL_W = (NUM_OSC > 1) ? $clog2(NUM_OSC) : 1;

  strobe_t          stb;
  logic [SEL_W-1:0] oscSel;
  logic [REG_W-1:0] ctrlQ;
  logic [1:0]       statQ;
  logic [REG_W-1:0] rtnQ;
  logic [DEV_W-1:0] ctrlDev;
  logic [FN_W-1:0]  ctrlFn;
  logic             ctrlDir;

  cfgchan_ctrl #(.NUM_OSC(NUM_OSC), .SEL_W(SEL_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busGoBit(busWrData[GO_BIT]), .ctrlDev(ctrlDev), .ctrlFn(ctrlFn),
    .ctrlDir(ctrlDir), .stb(stb), .oscSel(oscSel)
  );

  cfgchan_datapath #(.NUM_OSC(NUM_OSC), .SEL_W(SEL_W), .OSC_INIT(OSC_INIT)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .oscSel(oscSel), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData), .ctrlQ(ctrlQ),
    .statQ(statQ), .rtnQ(rtnQ), .ctrlDev(ctrlDev), .ctrlFn(ctrlFn),
    .ctrlDir(ctrlDir)
  );

endmodule

// File: rtl/cfgchan_chk.sv
module cfgchan_chk
  import cfgchan_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              busWrEn,
  input logic [ADDR_W-1:0] busAddr,
  input logic [REG_W-1:0]  busWrData,
  input logic [REG_W-1:0]  ctrlQ,
  input logic [1:0]        statQ,
  input logic [REG_W-1:0]  rtnQ
);

  logic ctrlWr;
  assign ctrlWr = busWrEn && (busAddr == OFS_CTRL);

  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlQ & ~CTRL_KEEP) == '0);

  a_r3_ctrl_clears_stat: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWr |=> statQ == 2'b00);

  a_r4_start_sets_done: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWr && busWrData[GO_BIT]) ##1 !ctrlWr |=> statQ[0]);

  a_r4_no_start_idle: assert property (@(posedge clk) disable iff (!rstN)
    (ctrlWr && !busWrData[GO_BIT]) ##1 !ctrlWr |=> statQ == 2'b00);

  a_r5_error_with_done: assert property (@(posedge clk) disable iff (!rstN)
    statQ[1] |-> statQ[0]);

  a_r5_error_keeps_rtn: assert property (@(posedge clk) disable iff (!rstN)
    $rose(statQ[1]) |-> $stable(rtnQ));

  a_r9_rtn_write_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (busWrEn && busAddr == OFS_RTN) |=> $stable(rtnQ));

endmodule

bind cfgchan_xact cfgchan_chk u_chk (
  .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
  .busWrData(busWrData), .ctrlQ(ctrlQ), .statQ(statQ), .rtnQ(rtnQ)
);

// File: tb/tb_cfgchan_xact.sv
`timescale 1ns/1ps
module tb_cfgchan_xact;

  localparam int NOSC = 3;
  localparam logic [NOSC*32-1:0] INIT = {32'hC0DE_0002, 32'hC0DE_0001, 32'hC0DE_0000};

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWrEn = 1'b0;
  logic [11:0] busAddr = '0;
  logic [31:0] busWrData = '0;
  logic [31:0] busRdData;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  typedef struct {
    logic [11:0] addr;
    logic [31:0] exp;
    string       tag;
  } item_t;
  item_t sbQ[$];

  always #2.5 clk = ~clk;

  cfgchan_xact #(.NUM_OSC(NOSC), .OSC_INIT(INIT)) dut (
    .clk(clk), .rstN(rstN), .busWrEn(busWrEn), .busAddr(busAddr),
    .busWrData(busWrData), .busRdData(busRdData)
  );

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); #1;
    busWrEn = 1'b1; busAddr = a; busWrData = d;
    @(negedge clk); #1;
    busWrEn = 1'b0;
  endtask

  task automatic expRd(input logic [11:0] a, input logic [31:0] e, input string tag);
    item_t it;
    @(negedge clk); #1;
    busAddr = a;
    it.addr = a; it.exp = e; it.tag = tag;
    sbQ.push_back(it);
  endtask

  always @(negedge clk) begin
    if (sbQ.size() > 0) begin
      item_t it;
      it = sbQ.pop_front();
      checks++;
      if (busRdData !== it.exp) begin
        errors++;
        $display("FAIL %s addr=%h actual=%h expected=%h", it.tag, it.addr, busRdData, it.exp);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    // R8 reset state, R1 read map
    expRd(12'h0A0, 32'h0, "R8 rtn reset");
    expRd(12'h0A4, 32'h0, "R8 out reset");
    expRd(12'h0A8, 32'h0010_0000, "R8 ctrl reset");
    expRd(12'h0AC, 32'h0, "R8 stat reset");
    expRd(12'h100, 32'h0, "R1 unmapped offset");
    // R7 read bank 1 reset value; R2 start stripped
    wr(12'h0A8, 32'h8010_0001);
    expRd(12'h0AC, 32'h1, "R4 done after read");
    expRd(12'h0A0, 32'hC0DE_0001, "R7 read bank1 (R8 init)");
    expRd(12'h0A8, 32'h0010_0001, "R2 start stripped");
    // R2 reserved bits, R5 bad function
    wr(12'h0A8, 32'hFFFF_FFFF);
    expRd(12'h0AC, 32'h3, "R5 bad fn error");
    expRd(12'h0A8, 32'h43F0_0FFF, "R2 reserved masked");
    expRd(12'h0A0, 32'hC0DE_0001, "R5 rtn kept on error");
    // R3 clear, R4 no start
    wr(12'h0A8, 32'h0010_0002);
    expRd(12'h0AC, 32'h0, "R3 R4 stat cleared, no start");
    expRd(12'h0A8, 32'h0010_0002, "R2 stored without start");
    // R6 write bank 2
    wr(12'h0A4, 32'hA5A5_1234);
    expRd(12'h0A4, 32'hA5A5_1234, "R9 out readback");
    wr(12'h0A8, 32'hC010_0002);
    expRd(12'h0AC, 32'h1, "R6 write done");
    expRd(12'h0A8, 32'h4010_0002, "R2 dir kept");
    wr(12'h0A8, 32'h8010_0002);
    expRd(12'h0A0, 32'hA5A5_1234, "R6 bank2 written");
    // R5 index boundary and large index
    wr(12'h0A4, 32'h0BAD_0BAD);
    wr(12'h0A8, 32'hC010_0003);
    expRd(12'h0AC, 32'h3, "R5 index==NUM_OSC error");
    wr(12'h0A8, 32'hC010_0FFF);
    expRd(12'h0AC, 32'h3, "R5 index 0xFFF error");
    wr(12'h0A8, 32'hC000_0000);
    expRd(12'h0AC, 32'h3, "R5 fn0 write error");
    wr(12'h0A8, 32'h8020_0000);
    expRd(12'h0AC, 32'h3, "R5 fn2 read error");
    expRd(12'h0A0, 32'hA5A5_1234, "R5 rtn kept fn2");
    for (int i = 0; i < NOSC; i++) begin
      wr(12'h0A8, 32'h8010_0000 | 32'(i));
      expRd(12'h0AC, 32'h1, "R7 read done");
      expRd(12'h0A0, (i == 2) ? 32'hA5A5_1234 : (32'hC0DE_0000 | 32'(i)),
            "R5 bank untouched by errors");
    end
    // R9 rtn write ignored
    wr(12'h0A0, 32'hDEAD_BEEF);
    expRd(12'h0A0, 32'hA5A5_1234, "R9 rtn write ignored");
    // R3 clear after error then no start
    wr(12'h0A8, 32'hC010_0009);
    expRd(12'h0AC, 32'h3, "R5 error set");
    wr(12'h0A8, 32'h0010_0000);
    expRd(12'h0AC, 32'h0, "R3 clear after error");
    @(negedge clk); #1;
    repeat (3) @(negedge clk);
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule